// File: doc/BRIEF.md
# Base/Mask Memory-Type Range Classifier

This block holds one 64-bit configuration register that describes two physical memory windows. Each window has a 15-bit base, a 15-bit mask and two memory-type flags: uncacheable and write-combining. Software reaches the register through a model-specific-register style access port, which has an address, a 64-bit write bus, a write strobe and a combinational read bus.

On every clock the block compares the processor's 32-bit physical address against both windows. A window matches when the masked base equals the masked upper 15 address bits. The granularity is therefore 128 Kbytes. The block registers a per-window hit vector and a merged memory-type indication. When windows overlap, uncacheable takes precedence over write-combining.

Top module: `memtype_range_cls`

## Requirements
- R1: The register is selected only by access address 32'hC000_0085. A write to any other address leaves the register unchanged, and a read of any other address returns zero.
- R2: Reset clears all 64 register bits. It also clears `range_hit`, `mt_uc` and `mt_wc`.
- R3: Field layout of window 0 in bits 31:0:
  - bit 0 is the uncacheable flag
  - bit 1 is the write-combining flag
  - bits 16:2 are the mask
  - bits 31:17 are the base

  Window 1 uses the same layout shifted up by 32 bits: UC at bit 32, WC at bit 33, mask at bits 48:34 and base at bits 63:49.
- R4: An address hits window n when (mask_n & base_n) == (mask_n & phys_addr[31:17]). Address bits 16:0 never affect the result. A mask of zero matches every address.
- R5: A write takes effect at the clock edge that samples the strobe. A read returns the full 64-bit register in the same cycle as the access address.
- R6: Outputs are registered. They reflect the address presented before a clock edge and the register contents held before that same edge. A write at the same edge affects only later results.
- R7: `mt_uc` is the OR of the UC flags of all hitting windows. `mt_wc` is 1 only when some hitting window has WC set and no hitting window has UC set. A window with both flags set reports uncacheable.
- R8: A hitting window whose UC and WC flags are both clear still sets its `range_hit` bit, but it drives neither memory-type output.
- R9: `range_hit[n]` reports window n: bit 0 for window 0, bit 1 for window 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 32 | Register access address |
| acc_wdata | input | 64 | Register write data |
| acc_wr | input | 1 | Write strobe |
| acc_rdata | output | 64 | Register read data, combinational |
| phys_addr | input | 32 | Physical address to classify |
| range_hit | output | 2 | Registered per-window hit vector |
| mt_uc | output | 1 | Registered uncacheable indication |
| mt_wc | output | 1 | Registered write-combining indication |

## Verification
The vector table pairs register images with probe addresses, and each pair separates one behaviour:
- The first and last 128-Kbyte-aligned addresses inside a wider window show that the mask defines the size.
- An address whose low 17 bits are all ones shows those bits are ignored.
- Addresses one granule past a window's top show that the window's edge is exact.
- Overlapping windows with mixed flags check the precedence of UC over WC.
- Flagless windows and zero masks separate the hit vector from the memory type.

Directed cases cover a write to a neighbouring address, a read in the same cycle as the address, and a write that coincides with a classification, which must use the old contents.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
   localparam int unsigned FLAG_UC = 0;
   localparam int unsigned FLAG_WC = 1;
   localparam int unsigned FLAG_W  = 2;
endpackage

// File: rtl/memtype_ctl_reg.sv
module memtype_ctl_reg #(
   parameter int unsigned REG_W   = 64,
   parameter int unsigned SEL_W   = 32,
   parameter logic [SEL_W-1:0] SEL_ADDR = 32'hC000_0085
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] acc_addr,
   input  logic [REG_W-1:0] acc_wdata,
   input  logic             acc_wr,
   output logic [REG_W-1:0] acc_rdata,
   output logic [REG_W-1:0] ctl_q
);
   logic sel;

   assign sel       = (acc_addr == SEL_ADDR);
   assign acc_rdata = sel ? ctl_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ctl_q <= '0;
      else if (acc_wr && sel) ctl_q <= acc_wdata;
   end

   AST_OFFADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_addr != SEL_ADDR) |=> $stable(ctl_q)); // R1

   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_addr == SEL_ADDR) |=> (ctl_q == $past(acc_wdata))); // R5
endmodule

// File: rtl/memtype_range_match.sv
module memtype_range_match
   import memtype_pkg::*;
#(
   parameter int unsigned PA_W   = 32,
   parameter int unsigned GRAN_W = 17,
   localparam int unsigned FIELD_W = PA_W - GRAN_W,
   localparam int unsigned SLOT_W  = 2*FIELD_W + FLAG_W
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [PA_W-1:0]   phys_addr,
   output logic              hit,
   output logic              uc_hit,
   output logic              wc_hit
);
   logic [FIELD_W-1:0] base_f, mask_f, page;

   assign mask_f = slot[FLAG_W +: FIELD_W];
   assign base_f = slot[FLAG_W+FIELD_W +: FIELD_W];
   assign page   = phys_addr[PA_W-1 -: FIELD_W];

   assign hit    = ((mask_f & base_f) == (mask_f & page));
   assign uc_hit = hit & slot[FLAG_UC];
   assign wc_hit = hit & slot[FLAG_WC];
endmodule

// File: rtl/memtype_type_merge.sv
module memtype_type_merge #(
   parameter int unsigned N_RANGE = 2
) (
   input  logic [N_RANGE-1:0] uc_hit,
   input  logic [N_RANGE-1:0] wc_hit,
   output logic               uc,
   output logic               wc
);
   always_comb begin
      uc = 1'b0;
      wc = 1'b0;
      for (int i = 0; i < N_RANGE; i++) begin
         uc = uc | uc_hit[i];
         wc = wc | wc_hit[i];
      end
      wc = wc & ~uc;
   end
endmodule

// File: rtl/memtype_range_cls.sv
module memtype_range_cls
   import memtype_pkg::*;
#(
   parameter int unsigned PA_W   = 32,
   parameter int unsigned GRAN_W = 17,
   parameter int unsigned REG_W  = 64,
   parameter int unsigned SEL_W  = 32,
   parameter logic [SEL_W-1:0] SEL_ADDR = 32'hC000_0085,
   localparam int unsigned FIELD_W = PA_W - GRAN_W,
   localparam int unsigned SLOT_W  = 2*FIELD_W + FLAG_W,
   localparam int unsigned N_RANGE = REG_W / SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   acc_addr,
   input  logic [REG_W-1:0]   acc_wdata,
   input  logic               acc_wr,
   output logic [REG_W-1:0]   acc_rdata,
   input  logic [PA_W-1:0]    phys_addr,
   output logic [N_RANGE-1:0] range_hit,
   output logic               mt_uc,
   output logic               mt_wc
);
   if (GRAN_W >= PA_W) begin : g_bad_gran
      $error("GRAN_W must be below PA_W");
   end
   if (REG_W % SLOT_W != 0 || N_RANGE == 0) begin : g_bad_pack
      $error("REG_W must hold a whole number of range slots");
   end

   logic [REG_W-1:0]   ctl_q;
   logic [N_RANGE-1:0] hit_c, uc_c, wc_c;
   logic               uc_m, wc_m;

   memtype_ctl_reg #(.REG_W(REG_W), .SEL_W(SEL_W), .SEL_ADDR(SEL_ADDR)) u_reg (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_wr(acc_wr), .acc_rdata(acc_rdata), .ctl_q(ctl_q)
   );

   for (genvar n = 0; n < N_RANGE; n++) begin : g_range
      memtype_range_match #(.PA_W(PA_W), .GRAN_W(GRAN_W)) u_match (
         .slot(ctl_q[n*SLOT_W +: SLOT_W]), .phys_addr(phys_addr),
         .hit(hit_c[n]), .uc_hit(uc_c[n]), .wc_hit(wc_c[n])
      );
   end

   memtype_type_merge #(.N_RANGE(N_RANGE)) u_merge (
      .uc_hit(uc_c), .wc_hit(wc_c), .uc(uc_m), .wc(wc_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         range_hit <= '0;
         mt_uc     <= 1'b0;
         mt_wc     <= 1'b0;
      end else begin
         range_hit <= hit_c;
         mt_uc     <= uc_m;
         mt_wc     <= wc_m;
      end
   end

   AST_UC_WC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mt_uc && mt_wc)); // R7

   AST_TYPE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_uc || mt_wc) |-> (range_hit != '0)); // R8
endmodule

// File: tb/memtype_range_cls_test.sv
module memtype_range_cls_test;
   localparam int CLK_P = 10;
   localparam logic [31:0] SEL   = 32'hC000_0085;
   localparam int          N_VEC = 11;

   function automatic logic [31:0] mk(input logic [14:0] b, input logic [14:0] m,
                                      input logic wc, input logic uc);
      return {b, m, wc, uc};
   endfunction

   // entry: {reg[63:0], addr[31:0], hit[1:0], uc, wc}
   localparam logic [99:0] VEC [N_VEC] = '{
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h0020_0000, 2'b01, 1'b1, 1'b0},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h0201_2345, 2'b10, 1'b0, 1'b1},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h03FF_FFFF, 2'b10, 1'b0, 1'b1},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h0400_0000, 2'b00, 1'b0, 1'b0},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h0021_FFFF, 2'b01, 1'b1, 1'b0},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0010, 15'h7FFF, 0, 1), 32'h0022_0000, 2'b00, 1'b0, 1'b0},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0100, 15'h7FFF, 0, 1), 32'h0200_0000, 2'b11, 1'b1, 1'b0},
      {mk(15'h0100, 15'h7F00, 1, 0), mk(15'h0100, 15'h7FFF, 1, 0), 32'h0200_0000, 2'b11, 1'b0, 1'b1},
      {mk(15'h0000, 15'h0000, 0, 0), mk(15'h0010, 15'h7FFF, 0, 0), 32'h0020_0000, 2'b11, 1'b0, 1'b0},
      {mk(15'h7FFF, 15'h7FFF, 1, 0), mk(15'h0010, 15'h7FFF, 1, 1), 32'h0020_0000, 2'b01, 1'b1, 1'b0},
      {mk(15'h7FFF, 15'h7FFF, 1, 0), mk(15'h0010, 15'h7FFF, 1, 1), 32'hFFFF_FFFF, 2'b10, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [63:0] acc_wdata = '0;
   logic        acc_wr = 1'b0;
   logic [63:0] acc_rdata;
   logic [31:0] phys_addr = '0;
   logic [1:0]  range_hit;
   logic        mt_uc, mt_wc;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   memtype_range_cls uut (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_wr(acc_wr), .acc_rdata(acc_rdata), .phys_addr(phys_addr),
      .range_hit(range_hit), .mt_uc(mt_uc), .mt_wc(mt_wc)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [31:0] a, input logic [63:0] d);
      @(negedge clk);
      acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0; acc_addr = SEL;
   endtask

   task automatic classify(input logic [31:0] pa);
      phys_addr = pa;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P*200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      acc_addr = SEL; #1;
      chk("R2 reg cleared", acc_rdata, 64'h0);
      chk("R2 outputs cleared", {60'h0, range_hit, mt_uc, mt_wc}, 64'h0);
      rst_n = 1'b1;

      // R3 R4 R7 R9: vector table
      for (int i = 0; i < N_VEC; i++) begin
         wr_reg(SEL, VEC[i][99:36]);
         classify(VEC[i][35:4]);
         chk($sformatf("R4/R9 hit vec %0d", i), {62'h0, range_hit}, {62'h0, VEC[i][3:2]});
         chk($sformatf("R7 uc vec %0d", i), {63'h0, mt_uc}, {63'h0, VEC[i][1]});
         chk($sformatf("R3 wc vec %0d", i), {63'h0, mt_wc}, {63'h0, VEC[i][0]});
      end

      // R8: flagless hit drives no type (vector 8 also)
      wr_reg(SEL, {mk(15'h0, 15'h0, 0, 0), mk(15'h0, 15'h0, 0, 0)});
      classify(32'h1234_5678);
      chk("R8 hit no type", {60'h0, range_hit, mt_uc, mt_wc}, {60'h0, 2'b11, 2'b00});

      // R5: write then same-cycle full readback
      wr_reg(SEL, 64'hDEAD_BEEF_0123_4567);
      acc_addr = SEL; #1;
      chk("R5 readback", acc_rdata, 64'hDEAD_BEEF_0123_4567);

      // R1: neighbour address write ignored, other reads zero
      wr_reg(32'hC000_0086, 64'h1111_2222_3333_4444);
      acc_addr = SEL; #1;
      chk("R1 off write ignored", acc_rdata, 64'hDEAD_BEEF_0123_4567);
      acc_addr = 32'hC000_0084; #1;
      chk("R1 off read zero", acc_rdata, 64'h0);
      acc_addr = SEL;

      // R6: write at same edge as classification uses old contents
      wr_reg(SEL, {mk(15'h7FFF, 15'h7FFF, 0, 0), mk(15'h0010, 15'h7FFF, 0, 1)});
      @(negedge clk);
      phys_addr = 32'h0020_0000;
      acc_addr = SEL; acc_wdata = {mk(15'h7FFF, 15'h7FFF, 0, 0), mk(15'h0010, 15'h7FFF, 1, 0)};
      acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
      chk("R6 old contents used", {62'h0, mt_uc, mt_wc}, {62'h0, 2'b10});
      @(negedge clk);
      chk("R6 new contents next", {62'h0, mt_uc, mt_wc}, {62'h0, 2'b01});

      // R2: reset mid-run clears register and outputs
      rst_n = 1'b0; #1;
      chk("R2 reset reg", acc_rdata, 64'h0);
      chk("R2 reset outputs", {60'h0, range_hit, mt_uc, mt_wc}, 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule